// File: doc/BRIEF.md
# Single-Segment Host DMA Engine

This block is the built-in DMA mover of an SD host controller. Each transfer copies one contiguous buffer between system memory and the controller's data FIFO. Software sets up a mode register: the transfer direction, the beat width and whether the address advances. It loads a 64-bit start address as two 32-bit halves and then writes a start bit. The engine then runs one beat at a time. Toward the card, it reads a beat from memory and pushes it into the FIFO. From the card, it pops a beat from the FIFO and writes it to memory.

The transfer length comes from the controller as a block count and a block size in bytes. The number of beats is the byte total divided by the beat width. The engine raises a one-cycle done pulse after the final beat is accepted. A two-bit channel-reset register holds each direction's channel in reset while its bit is 0. Clearing the bit aborts a running transfer, and setting it again allows new transfers.

Top module: `sdh_dma_engine`

## Requirements
- R1: After reset, the mode, low-address and high-address registers read 0, the channel-reset register reads 0x300, the control register reads 0, and mem_req, fifo_push, fifo_pop and done are low.
- R2: The mode register bits [17:16] select the direction and read back as written. Code 0 reads memory (mem_we=0) and pushes into the FIFO. Code 1 pops the FIFO and writes memory (mem_we=1).
- R3: The mode register bits [5:4] select the beat width: 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. mem_size carries this code on every request. A transfer makes exactly (blk_count*blk_size) >> code beats.
- R4: When mode bit 0 is 1, the address of beat i is start + i*beat_bytes. When mode bit 0 is 0, every beat uses the start address.
- R5: The start address is {high register, low register}, at offsets 0x10 and 0x0C. The first beat is issued at exactly that address.
- R6: Writing 1 to bit 0 of the control register (offset 0x04) starts a transfer. That bit reads 1 while a transfer runs and returns to 0 by itself when the transfer ends.
- R7: done is high for exactly one cycle per transfer, in the cycle after the final beat is accepted. A transfer of zero beats gives one done pulse and no memory or FIFO activity.
- R8: A start is ignored when address bits [2:0] are not 0 or the direction code is 2 or 3. An ignored start makes no memory request, no done pulse, and the control register reads 0.
- R9: Bits 8 and 9 of the channel-reset register (offset 0x08) belong to the to-device and from-device channels. Writing 0 to the active channel's bit stops the transfer: mem_req drops and no done pulse follows. A start for a channel whose bit is 0 is ignored.
- R10: Data keeps its order. Toward the card, FIFO push i carries memory read data i. From the card, memory write i carries FIFO pop data i.
- R11: A start written while a transfer runs is ignored, and the running transfer keeps its beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| blk_count | input | 16 | Number of blocks in the transfer |
| blk_size | input | 12 | Block size in bytes |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 64 | Memory byte address |
| mem_size | output | 2 | Beat width code of the request |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| fifo_push | output | 1 | Push a beat into the FIFO |
| fifo_wdata | output | 64 | Data pushed into the FIFO |
| fifo_full | input | 1 | FIFO cannot take a beat |
| fifo_pop | output | 1 | Pop a beat from the FIFO |
| fifo_rdata | input | 64 | Head of the FIFO (show-ahead) |
| fifo_empty | input | 1 | FIFO holds no beat |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is an abort that arrives while a memory request is waiting for its acknowledge. For that, the request must be in flight and the channel-reset write must land before the acknowledge does. The bench starts a long transfer and waits until it sees mem_req high. It then clears the channel bit while the memory model holds back its acknowledge. Next it checks that the request falls, that no done pulse follows, and that the engine starts again once the bit is set. A sweep over every direction, width and increment setting against small block counts and sizes covers the beat arithmetic. FIFO full/empty and acknowledge delays follow fixed patterns, so the stalls land on different beats from one transfer to the next.

// File: rtl/sdh_dma_pkg.sv
// Shared definitions for the single-segment host DMA engine.
// Assumes byte addressing and a 64-bit memory data path.
package sdh_dma_pkg;

    localparam int MEM_AW = 64;
    localparam int MEM_DW = 64;

    // Register byte offsets
    localparam logic [4:0] OFS_MODE    = 5'h00;
    localparam logic [4:0] OFS_CTRL    = 5'h04;
    localparam logic [4:0] OFS_CHRST   = 5'h08;
    localparam logic [4:0] OFS_ADDR_LO = 5'h0C;
    localparam logic [4:0] OFS_ADDR_HI = 5'h10;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_MEM_RD = 3'd1,
        ST_PUSH   = 3'd2,
        ST_POP    = 3'd3,
        ST_MEM_WR = 3'd4
    } xfer_st_e;

    typedef struct packed {
        logic [1:0]        dir_code;
        logic [1:0]        width;
        logic              incr;
        logic [MEM_AW-1:0] base;
    } xfer_cfg_t;

endpackage

// File: rtl/sdh_dma_regs.sv
// Register file of the DMA engine: mode, control, channel reset and start address.
// Assumes single-cycle writes and a combinational read path on reg_addr.
module sdh_dma_regs
    import sdh_dma_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int REG_DW = 32,
    parameter int N_CHAN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              busy,
    output logic              start_req,
    output xfer_cfg_t         cfg,
    output logic [N_CHAN-1:0] chan_run
);

    localparam int CHRST_LSB = 8;

    logic [1:0]        dir_q;
    logic [1:0]        width_q;
    logic              incr_q;
    logic [REG_DW-1:0] addr_lo_q;
    logic [REG_DW-1:0] addr_hi_q;
    logic [N_CHAN-1:0] run_q;

    // Register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= '0;
            width_q   <= '0;
            incr_q    <= 1'b0;
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            run_q     <= '1;
        end else if (reg_wr) begin
            case (reg_addr)
                OFS_MODE: begin
                    dir_q   <= reg_wdata[17:16];
                    width_q <= reg_wdata[5:4];
                    incr_q  <= reg_wdata[0];
                end
                OFS_CHRST:   run_q     <= reg_wdata[CHRST_LSB +: N_CHAN];
                OFS_ADDR_LO: addr_lo_q <= reg_wdata;
                OFS_ADDR_HI: addr_hi_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Start strobe: self-clearing, it lives only in the write cycle
    assign start_req = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[0];

    assign cfg.dir_code = dir_q;
    assign cfg.width    = width_q;
    assign cfg.incr     = incr_q;
    assign cfg.base     = {addr_hi_q, addr_lo_q};
    assign chan_run     = run_q;

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_MODE: begin
                reg_rdata[17:16] = dir_q;
                reg_rdata[5:4]   = width_q;
                reg_rdata[0]     = incr_q;
            end
            OFS_CTRL:    reg_rdata[0] = busy;
            OFS_CHRST:   reg_rdata[CHRST_LSB +: N_CHAN] = run_q;
            OFS_ADDR_LO: reg_rdata = addr_lo_q;
            OFS_ADDR_HI: reg_rdata = addr_hi_q;
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sdh_dma_addr_gen.sv
// Beat counter and address generator for one contiguous segment.
// Assumes the byte total is a multiple of the beat width; any remainder is dropped.
module sdh_dma_addr_gen
    import sdh_dma_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SIZE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  xfer_cfg_t         cfg,
    input  logic [CNT_W-1:0]  blk_count,
    input  logic [SIZE_W-1:0] blk_size,
    output logic              zero_len,
    output logic              last_beat,
    output logic [MEM_AW-1:0] cur_addr,
    output logic [1:0]        cur_width
);

    localparam int BEAT_W = CNT_W + SIZE_W;

    logic [BEAT_W-1:0] total_bytes;
    logic [BEAT_W-1:0] beats_calc;
    logic [BEAT_W-1:0] remain_q;
    logic              incr_q;
    logic [MEM_AW-1:0] stride;

    // Beat count of the transfer about to start
    always_comb begin
        total_bytes = BEAT_W'(blk_count) * BEAT_W'(blk_size);
        beats_calc  = total_bytes >> cfg.width;
    end

    assign zero_len  = (beats_calc == '0);
    assign last_beat = (remain_q == BEAT_W'(1));
    assign stride    = incr_q ? (MEM_AW'(1) << cur_width) : '0;

    // Address and remaining-beat registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q  <= '0;
            cur_addr  <= '0;
            cur_width <= '0;
            incr_q    <= 1'b0;
        end else if (load) begin
            remain_q  <= beats_calc;
            cur_addr  <= cfg.base;
            cur_width <= cfg.width;
            incr_q    <= cfg.incr;
        end else if (step) begin
            remain_q <= remain_q - BEAT_W'(1);
            cur_addr <= cur_addr + stride;
        end
    end

endmodule

// File: rtl/sdh_dma_xfer_fsm.sv
// Beat sequencer: memory-to-FIFO or FIFO-to-memory, one beat in flight.
// Assumes a show-ahead FIFO and a memory that holds read data with mem_ack.
module sdh_dma_xfer_fsm
    import sdh_dma_pkg::*;
#(
    parameter int N_CHAN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  xfer_cfg_t         cfg,
    input  logic [N_CHAN-1:0] chan_run,
    input  logic              zero_len,
    input  logic              last_beat,
    output logic              load,
    output logic              step,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MEM_DW-1:0] mem_wdata,
    input  logic [MEM_DW-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              fifo_push,
    output logic [MEM_DW-1:0] fifo_wdata,
    input  logic              fifo_full,
    output logic              fifo_pop,
    input  logic [MEM_DW-1:0] fifo_rdata,
    input  logic              fifo_empty
);

    xfer_st_e          st_q;
    logic              dir_q;
    logic              done_q;
    logic [MEM_DW-1:0] hold_q;
    logic              cfg_ok;
    logic              accept;
    logic              chan_ok;

    // Start qualification: legal direction, 8-byte alignment, channel out of reset
    always_comb begin
        cfg_ok = !cfg.dir_code[1] && (cfg.base[2:0] == 3'b000) && chan_run[cfg.dir_code[0]];
        accept = start_req && (st_q == ST_IDLE) && cfg_ok;
    end

    assign chan_ok = chan_run[dir_q];

    // Handshake outputs, dropped at once when the active channel is held in reset
    always_comb begin
        mem_req   = chan_ok && ((st_q == ST_MEM_RD) || (st_q == ST_MEM_WR));
        mem_we    = (st_q == ST_MEM_WR);
        fifo_push = chan_ok && (st_q == ST_PUSH) && !fifo_full;
        fifo_pop  = chan_ok && (st_q == ST_POP) && !fifo_empty;
        load      = accept && !zero_len;
        step      = fifo_push || (mem_req && mem_we && mem_ack);
        busy      = (st_q != ST_IDLE);
    end

    assign mem_wdata  = hold_q;
    assign fifo_wdata = hold_q;
    assign done       = done_q;

    // State sequencing and data hold register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            dir_q  <= 1'b0;
            done_q <= 1'b0;
            hold_q <= '0;
        end else begin
            done_q <= 1'b0;
            if ((st_q != ST_IDLE) && !chan_ok) begin
                st_q <= ST_IDLE;
            end else begin
                case (st_q)
                    ST_IDLE: if (accept) begin
                        dir_q <= cfg.dir_code[0];
                        if (zero_len)          done_q <= 1'b1;
                        else if (cfg.dir_code[0]) st_q <= ST_POP;
                        else                   st_q <= ST_MEM_RD;
                    end
                    ST_MEM_RD: if (mem_ack) begin
                        hold_q <= mem_rdata;
                        st_q   <= ST_PUSH;
                    end
                    ST_PUSH: if (!fifo_full) begin
                        if (last_beat) begin
                            st_q   <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            st_q <= ST_MEM_RD;
                        end
                    end
                    ST_POP: if (!fifo_empty) begin
                        hold_q <= fifo_rdata;
                        st_q   <= ST_MEM_WR;
                    end
                    ST_MEM_WR: if (mem_ack) begin
                        if (last_beat) begin
                            st_q   <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            st_q <= ST_POP;
                        end
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/sdh_dma_engine.sv
// Top of the single-segment host DMA engine: registers, address generator, sequencer.
// Assumes one contiguous, 8-byte aligned buffer per transfer.
module sdh_dma_engine
    import sdh_dma_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int REG_DW = 32,
    parameter int CNT_W  = 16,
    parameter int SIZE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic [CNT_W-1:0]  blk_count,
    input  logic [SIZE_W-1:0] blk_size,
    output logic              mem_req,
    output logic              mem_we,
    output logic [63:0]       mem_addr,
    output logic [1:0]        mem_size,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              fifo_push,
    output logic [63:0]       fifo_wdata,
    input  logic              fifo_full,
    output logic              fifo_pop,
    input  logic [63:0]       fifo_rdata,
    input  logic              fifo_empty,
    output logic              done
);

    localparam int N_CHAN = 2;

    xfer_cfg_t         cfg;
    logic [N_CHAN-1:0] chan_run;
    logic              start_req;
    logic              busy;
    logic              load;
    logic              step;
    logic              zero_len;
    logic              last_beat;

    sdh_dma_regs #(.REG_AW(REG_AW), .REG_DW(REG_DW), .N_CHAN(N_CHAN)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .start_req(start_req), .cfg(cfg), .chan_run(chan_run)
    );

    sdh_dma_addr_gen #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .cfg(cfg),
        .blk_count(blk_count), .blk_size(blk_size), .zero_len(zero_len),
        .last_beat(last_beat), .cur_addr(mem_addr), .cur_width(mem_size)
    );

    sdh_dma_xfer_fsm #(.N_CHAN(N_CHAN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .cfg(cfg),
        .chan_run(chan_run), .zero_len(zero_len), .last_beat(last_beat),
        .load(load), .step(step), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .fifo_push(fifo_push),
        .fifo_wdata(fifo_wdata), .fifo_full(fifo_full), .fifo_pop(fifo_pop),
        .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty)
    );

endmodule

// File: rtl/sdh_dma_checker.sv
// Protocol checker for the DMA engine, bound to the top module.
// Assumes it sees the top's ports plus its internal busy flag.
module sdh_dma_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [63:0] mem_addr,
    input logic [1:0]  mem_size,
    input logic        fifo_push,
    input logic        fifo_pop,
    input logic        done
);

    // R7: done never lasts two cycles
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: a waiting request keeps its address unless a register write intervenes
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !reg_wr) |=> (mem_req && $stable(mem_addr)));

    // R8: every request is aligned to its beat width
    assert_req_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr & ((64'd1 << mem_size) - 64'd1)) == 64'd0));

    // R6: no handshake activity while idle
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !fifo_push && !fifo_pop));

    // R2: at most one of request, push and pop in a cycle
    assert_one_action_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, fifo_push, fifo_pop}));

endmodule

bind sdh_dma_engine sdh_dma_checker u_sdh_dma_checker (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .busy(busy),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_size(mem_size), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
    .done(done)
);

// File: tb/test_sdh_dma_engine.sv
// Bench: sweep of direction, width, increment and length, plus abort and rejected-start cases.
module test_sdh_dma_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] blk_count = '0;
    logic [11:0] blk_size = '0;
    logic        mem_req, mem_we;
    logic [63:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic [63:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        fifo_push, fifo_pop, done;
    logic [63:0] fifo_wdata;
    logic        fifo_full = 1'b0;
    logic [63:0] fifo_rdata = '0;
    logic        fifo_empty = 1'b1;

    int checks = 0, failures = 0, cyc = 0, cyc_b = 0;
    int nmem = 0, npush = 0, npop = 0, ndone = 0, mwait = 0;
    bit mon_on = 1'b0, finished = 1'b0;
    logic [63:0] cur_base = '0;
    int cur_dir = 0, cur_w = 0, cur_inc = 0;

    sdh_dma_engine i_sdh_dma_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .blk_count(blk_count),
        .blk_size(blk_size), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .fifo_push(fifo_push),
        .fifo_wdata(fifo_wdata), .fifo_full(fifo_full), .fifo_pop(fifo_pop),
        .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty), .done(done)
    );

    always #5 clk = ~clk;

    function automatic logic [63:0] mpat(input logic [63:0] a);
        return {a[31:0] ^ 32'h5A5A_C3C3, ~a[31:0]};
    endfunction

    function automatic logic [63:0] fpat(input int i);
        return 64'hF00D_0000_0000_0000 | (64'(i) * 64'h0001_0101_0101);
    endfunction

    function automatic logic [63:0] exp_addr(input int i);
        return cur_base + (cur_inc != 0 ? 64'(i) * (64'd1 << cur_w) : 64'd0);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int k = 0; k < 3000; k++) begin
            rd(5'h04, v);
            if (v[0] == 1'b0) break;
        end
    endtask

    task automatic clear_counts();
        @(negedge clk);
        nmem = 0; npush = 0; npop = 0; ndone = 0; mwait = 0;
    endtask

    // Memory model, FIFO monitor and done counter, sampled at the falling edge
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (mwait != 0) mwait--;
            else begin
                mem_ack = 1'b1;
                mem_rdata = mpat(mem_addr);
                if (mon_on) begin
                    chk(mem_addr == exp_addr(nmem), "R4 R5 beat address", mem_addr, exp_addr(nmem));
                    chk(mem_we == cur_dir[0], "R2 direction", 64'(mem_we), 64'(cur_dir));
                    chk(mem_size == cur_w[1:0], "R3 size code", 64'(mem_size), 64'(cur_w));
                    if (cur_dir == 1) chk(mem_wdata == fpat(nmem), "R10 write data order", mem_wdata, fpat(nmem));
                end
                nmem++;
                mwait = nmem % 3;
            end
        end
        if (fifo_push) begin
            if (mon_on) chk(fifo_wdata == mpat(exp_addr(npush)), "R10 push data order", fifo_wdata, mpat(exp_addr(npush)));
            npush++;
        end
        if (fifo_pop) npop++;
        if (done) ndone++;
    end

    // FIFO stimulus, changed just after the rising edge
    always @(posedge clk) begin
        #1;
        cyc_b++;
        fifo_full  = (cyc_b % 5) == 2;
        fifo_empty = (cyc_b % 4) == 1;
        fifo_rdata = fpat(npop);
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic run_xfer(input int dir, input int w, input int inc, input int cnt,
                            input int sz, input logic [63:0] base, input bit restart);
        logic [31:0] v;
        int beats;
        clear_counts();
        cur_dir = dir; cur_w = w; cur_inc = inc; cur_base = base;
        blk_count = 16'(cnt); blk_size = 12'(sz); mon_on = 1'b1;
        beats = (cnt * sz) >> w;
        wr(5'h00, (32'(dir) << 16) | (32'(w) << 4) | 32'(inc));
        wr(5'h0C, base[31:0]);
        wr(5'h10, base[63:32]);
        rd(5'h00, v);
        chk(v == ((32'(dir) << 16) | (32'(w) << 4) | 32'(inc)), "R2 mode readback", 64'(v), 64'((dir << 16) | (w << 4) | inc));
        wr(5'h04, 32'h1);
        if (beats > 0) begin
            rd(5'h04, v);
            chk(v[0] == 1'b1, "R6 busy after start", 64'(v[0]), 64'd1);
        end
        if (restart) begin
            repeat (4) @(negedge clk);
            wr(5'h04, 32'h1); // R11 second start while running
        end
        wait_idle();
        repeat (3) @(negedge clk);
        rd(5'h04, v);
        chk(v[0] == 1'b0, "R6 start bit self-clears", 64'(v[0]), 64'd0);
        chk(nmem == beats, restart ? "R11 beat count after restart attempt" : "R3 beat count", 64'(nmem), 64'(beats));
        if (dir == 0) chk(npush == beats && npop == 0, "R10 push count", 64'(npush), 64'(beats));
        else          chk(npop == beats && npush == 0, "R10 pop count", 64'(npop), 64'(beats));
        chk(ndone == 1, "R7 one done pulse", 64'(ndone), 64'd1);
    endtask

    task automatic rejected_start(input logic [31:0] mode, input logic [31:0] lo, input string tag);
        logic [31:0] v;
        clear_counts();
        mon_on = 1'b0;
        blk_count = 16'd2; blk_size = 12'd16;
        wr(5'h00, mode);
        wr(5'h0C, lo);
        wr(5'h04, 32'h1);
        rd(5'h04, v);
        chk(v[0] == 1'b0, tag, 64'(v[0]), 64'd0);
        repeat (12) @(negedge clk);
        chk(nmem == 0 && ndone == 0, tag, 64'(nmem + ndone), 64'd0);
    endtask

    task automatic abort_case(input int dir);
        logic [31:0] v;
        clear_counts();
        mon_on = 1'b0;
        blk_count = 16'd2; blk_size = 12'd16;
        wr(5'h0C, 32'h0000_1000);
        wr(5'h00, (32'(dir) << 16) | 32'h1);
        wr(5'h04, 32'h1);
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (mem_req && nmem >= 3) break;
        end
        wr(5'h08, dir == 0 ? 32'h200 : 32'h100); // R9 clear the active channel
        repeat (2) @(negedge clk);
        chk(mem_req == 1'b0, "R9 request dropped on channel reset", 64'(mem_req), 64'd0);
        rd(5'h04, v);
        chk(v[0] == 1'b0, "R9 engine idle after channel reset", 64'(v[0]), 64'd0);
        repeat (20) @(negedge clk);
        chk(ndone == 0, "R9 no done after abort", 64'(ndone), 64'd0);
        clear_counts();
        wr(5'h04, 32'h1);
        repeat (10) @(negedge clk);
        chk(nmem == 0 && ndone == 0, "R9 start ignored while channel held", 64'(nmem + ndone), 64'd0);
        wr(5'h08, 32'h300);
        rd(5'h08, v);
        chk(v == 32'h300, "R9 channel register readback", 64'(v), 64'h300);
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        chk(mem_req == 0 && fifo_push == 0 && fifo_pop == 0 && done == 0, "R1 outputs in reset",
            64'({mem_req, fifo_push, fifo_pop, done}), 64'd0);
        rst_n = 1'b1;
        rd(5'h00, v); chk(v == 32'h0, "R1 mode reset", 64'(v), 64'h0);
        rd(5'h04, v); chk(v == 32'h0, "R1 control reset", 64'(v), 64'h0);
        rd(5'h08, v); chk(v == 32'h300, "R1 channel reset value", 64'(v), 64'h300);
        rd(5'h0C, v); chk(v == 32'h0, "R1 low address reset", 64'(v), 64'h0);
        rd(5'h10, v); chk(v == 32'h0, "R1 high address reset", 64'(v), 64'h0);

        // Sweep: direction x width x increment x length
        for (int d = 0; d < 2; d++)
            for (int w = 0; w < 4; w++)
                for (int inc = 0; inc < 2; inc++)
                    for (int c = 0; c < 3; c++)
                        for (int s = 0; s < 2; s++)
                            run_xfer(d, w, inc, c, 8 + 8 * s,
                                     {32'h0000_00A0 + 32'(d * 16 + w), 32'h1000_0000 + 32'(c * 256 + w * 64)},
                                     (w == 0 && c == 2 && s == 1));

        rejected_start(32'h0000_0001, 32'h0000_2004, "R8 misaligned start ignored");
        rejected_start(32'h0002_0001, 32'h0000_2000, "R8 reserved direction ignored");
        abort_case(0);
        abort_case(1);
        run_xfer(1, 3, 1, 1, 16, 64'hFFFF_FFFF_FFFF_FF00, 1'b0); // R5 full 64-bit address

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule